// File: doc/BRIEF.md
# Beat-Edge Timestamp Capture Unit

This block is the digital core of a dual-mixer time-difference measurement. Every channel receives a clock under test on `beat_in`. A flip-flop clocked by the common reference clock samples that input and acts as the mixer, so its output is the low-frequency beat between the two frequencies. The mixer output then passes through a settling chain of further register stages, which contains metastability from near-coincident input and clock edges. A run-length filter follows. It accepts a new beat level only after `FILT_LEN` consecutive samples of that level, so the burst of glitches around each beat transition produces one event and no more.

Each accepted level change captures the value of a free-running reference-clock counter. The captured value goes into a per-channel holding slot and then into a shared first-word-fall-through FIFO, tagged with the channel index and the edge direction. All channels share the one counter. Host-side software reads the FIFO and unwraps the modulo-2^`CNT_W` counter values. Each channel has an enable, and a sticky flag reports any event lost to a full FIFO.

Top module: `beat_stamp_top`

## Requirements
- R1: After reset, `rd_valid`, `fifo_full` and `ovf` are 0, the counter is 0, and every channel's accepted level is 0.
- R2: The `CNT_W`-bit counter is cleared only by reset and rises by one in every cycle, wrapping modulo 2^`CNT_W`. An entry's `rd_stamp` equals the counter value in the cycle the filter accepts the new level. That value is P + `SYNC_STAGES` + `FILT_LEN`, where P is the counter value in the cycle the new level is first presented on `beat_in`.
- R3: A channel accepts a new level only after `FILT_LEN` consecutive filter samples that differ from its current level. Any shorter run produces no entry, and a burst of short pulses followed by a settled level produces exactly one entry.
- R4: Each entry carries the channel index on `rd_chan`. `rd_rise` is 1 for a 0-to-1 accepted change and 0 for a 1-to-0 change.
- R5: When several channels accept in the same cycle, their entries enter the FIFO on successive cycles in ascending channel order, all with the same stamp. At most one entry is written per cycle.
- R6: No accepted edge is lost while the FIFO has room, and the entries of any one channel leave the FIFO in the order they were accepted. This is guaranteed by the elaboration-time requirement `FILT_LEN` >= `NUM_CH`.
- R7: `rd_valid` is 1 exactly when the FIFO holds an entry, and `rd_stamp`/`rd_chan`/`rd_rise` then show the oldest entry. `rd_en` high with `rd_valid` high removes that entry at the clock edge, and `rd_en` is ignored when the FIFO is empty.
- R8: `fifo_full` is 1 when `FIFO_DEPTH` entries are held. A write attempted while full is discarded, and `ovf` is 1 from the next cycle.
- R9: `ovf` stays 1 until a cycle with `ovf_clr` high clears it. If a discarded write falls in the same cycle as `ovf_clr`, `ovf` remains 1.
- R10: While `ch_en[i]` is low, channel i accepts no level change, keeps its accepted level, and restarts its run count. After re-enable, an input that differs from the kept level is accepted after `FILT_LEN` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock: mixer sampling clock and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| beat_in | input | NUM_CH | Clocks under test, one per channel, sampled by the mixer flops |
| ch_en | input | NUM_CH | Per-channel enable for edge acceptance |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rd_stamp | output | CNT_W | Counter value of the oldest entry |
| rd_chan | output | CH_W | Channel index of the oldest entry |
| rd_rise | output | 1 | 1 = rising accepted change, 0 = falling |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| ovf | output | 1 | Sticky flag: an entry was discarded on a full FIFO |

## Verification
Two functions can fall in the same cycle: acceptance on several channels at once, and the resulting entry writes competing for a single FIFO write port. The bench provokes this by inverting all channel inputs in one cycle while reads are stopped. It then drains the FIFO and judges that the entries appear in ascending channel order with one common stamp. The same clash occurs at random throughout a long constrained-random run. There, every popped entry is matched against per-channel expected queues built from the filter rule, so neither ordering nor loss can hide.

// File: rtl/beat_stamp_pkg.sv
package beat_stamp_pkg;

   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_dir_e;

   // index width that never collapses to zero bits
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/beat_chan_filter.sv
module beat_chan_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat_in,
   input  logic en,
   output logic accept,
   output logic new_lvl,
   output logic level
);
   localparam int RUN_W = beat_stamp_pkg::idx_width(FILT_LEN);

   logic mix_q;
   logic samp;
   logic lvl_q;
   logic differ;

   // mixer flop: reference clock samples the clock under test
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mix_q <= 1'b0;
      else        mix_q <= beat_in;
   end

   // settling chain
   generate
      if (SYNC_STAGES == 1) begin : g_sync_one
         logic s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= 1'b0;
            else        s_q <= mix_q;
         end
         assign samp = s_q;
      end else begin : g_sync_chain
         logic [SYNC_STAGES-1:0] s_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= {s_q[SYNC_STAGES-2:0], mix_q};
         end
         assign samp = s_q[SYNC_STAGES-1];
      end
   endgenerate

   assign differ = samp ^ lvl_q;

   // run-length acceptance
   generate
      if (FILT_LEN == 1) begin : g_no_filter
         assign accept = en & differ;
      end else begin : g_run_filter
         logic [RUN_W-1:0] run_q;
         assign accept = en & differ & (run_q == RUN_W'(FILT_LEN - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                         run_q <= '0;
            else if (!en || !differ || accept)  run_q <= '0;
            else                                run_q <= run_q + RUN_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl_q <= 1'b0;
      else if (accept) lvl_q <= samp;
   end

   assign new_lvl = samp;
   assign level   = lvl_q;

endmodule

// File: rtl/beat_pend_arb.sv
module beat_pend_arb #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32,
   localparam int CH_W  = beat_stamp_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] acc,
   input  logic [NUM_CH-1:0] rise_in,
   input  logic [CNT_W-1:0]  stamp,
   output logic              wr_req,
   output logic [CNT_W-1:0]  wr_stamp,
   output logic [CH_W-1:0]   wr_chan,
   output logic              wr_rise,
   output logic [NUM_CH-1:0] grant
);
   logic [NUM_CH-1:0] vld_q;
   logic [NUM_CH-1:0] rise_q;
   logic [CNT_W-1:0]  st_q [NUM_CH];

   // fixed priority: lowest pending channel index wins
   always_comb begin
      grant   = '0;
      wr_chan = '0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (vld_q[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            wr_chan  = CH_W'(i);
         end
      end
   end

   assign wr_req   = |vld_q;
   assign wr_stamp = st_q[wr_chan];
   assign wr_rise  = rise_q[wr_chan];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         rise_q <= '0;
         for (int i = 0; i < NUM_CH; i++) st_q[i] <= '0;
      end else begin
         for (int i = 0; i < NUM_CH; i++) begin
            if (acc[i]) begin
               vld_q[i]  <= 1'b1;
               rise_q[i] <= rise_in[i];
               st_q[i]   <= stamp;
            end else if (grant[i]) begin
               vld_q[i]  <= 1'b0;
            end
         end
      end
   end

endmodule

// File: rtl/beat_fifo.sv
module beat_fifo #(
   parameter int DW    = 35,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic [DW-1:0] din,
   input  logic          pop_req,
   input  logic          ovf_clr,
   output logic [DW-1:0] dout,
   output logic          valid,
   output logic          full,
   output logic          ovf
);
   logic [DW-1:0] mem_q [DEPTH];
   logic [AW:0]   wp_q;
   logic [AW:0]   rp_q;
   logic          empty;
   logic          push;
   logic          pop;

   assign empty = (wp_q == rp_q);
   assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign push  = push_req & ~full;
   assign pop   = pop_req & ~empty;

   always_ff @(posedge clk) begin
      if (push) mem_q[wp_q[AW-1:0]] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (push) wp_q <= wp_q + (AW+1)'(1);
         if (pop)  rp_q <= rp_q + (AW+1)'(1);
      end
   end

   // sticky loss flag, a new loss outranks the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf <= 1'b0;
      else if (push_req && full) ovf <= 1'b1;
      else if (ovf_clr)          ovf <= 1'b0;
   end

   assign dout  = mem_q[rp_q[AW-1:0]];
   assign valid = ~empty;

endmodule

// File: rtl/beat_stamp_top.sv
module beat_stamp_top #(
   parameter int NUM_CH      = 4,
   parameter int CNT_W       = 32,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 8,
   parameter int FIFO_DEPTH  = 16,
   localparam int CH_W       = beat_stamp_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] beat_in,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              rd_en,
   input  logic              ovf_clr,
   output logic              rd_valid,
   output logic [CNT_W-1:0]  rd_stamp,
   output logic [CH_W-1:0]   rd_chan,
   output logic              rd_rise,
   output logic              fifo_full,
   output logic              ovf
);
   localparam int ENT_W = CNT_W + CH_W + 1;

   // elaboration-time parameter checks
   generate
      if (NUM_CH < 1) begin : g_bad_nch
         $error("beat_stamp_top: NUM_CH must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("beat_stamp_top: SYNC_STAGES must be at least 1");
      end
      if (FILT_LEN < NUM_CH) begin : g_bad_filt
         $error("beat_stamp_top: FILT_LEN must be >= NUM_CH so holding slots drain in time");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("beat_stamp_top: FIFO_DEPTH must be a power of two, at least 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("beat_stamp_top: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [NUM_CH-1:0] acc;
   logic [NUM_CH-1:0] rise_vec;
   logic [NUM_CH-1:0] chan_lvl;
   logic [NUM_CH-1:0] grant;
   logic              wr_req;
   logic [CNT_W-1:0]  wr_stamp;
   logic [CH_W-1:0]   wr_chan;
   logic              wr_rise;
   logic [ENT_W-1:0]  wr_ent;
   logic [ENT_W-1:0]  rd_ent;

   // shared free-running reference counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + CNT_W'(1);
   end

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
         beat_chan_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .FILT_LEN    (FILT_LEN)
         ) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .beat_in (beat_in[c]),
            .en      (ch_en[c]),
            .accept  (acc[c]),
            .new_lvl (rise_vec[c]),
            .level   (chan_lvl[c])
         );
      end
   endgenerate

   beat_pend_arb #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .rise_in  (rise_vec),
      .stamp    (cnt_q),
      .wr_req   (wr_req),
      .wr_stamp (wr_stamp),
      .wr_chan  (wr_chan),
      .wr_rise  (wr_rise),
      .grant    (grant)
   );

   assign wr_ent = {wr_rise, wr_chan, wr_stamp};

   beat_fifo #(
      .DW    (ENT_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (wr_req),
      .din      (wr_ent),
      .pop_req  (rd_en),
      .ovf_clr  (ovf_clr),
      .dout     (rd_ent),
      .valid    (rd_valid),
      .full     (fifo_full),
      .ovf      (ovf)
   );

   assign rd_stamp = rd_ent[CNT_W-1:0];
   assign rd_chan  = rd_ent[CNT_W +: CH_W];
   assign rd_rise  = rd_ent[ENT_W-1];

endmodule

// File: rtl/beat_stamp_chk.sv
module beat_stamp_chk #(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CNT_W-1:0]  cnt,
   input logic [NUM_CH-1:0] chan_lvl,
   input logic [NUM_CH-1:0] ch_en,
   input logic [NUM_CH-1:0] grant,
   input logic              wr_req,
   input logic              fifo_full,
   input logic              rd_valid,
   input logic              ovf,
   input logic              ovf_clr
);

   p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!rd_valid && !ovf && cnt == '0 && chan_lvl == '0));

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (cnt == $past(cnt) + CNT_W'(1)));

   p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   p_grant_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (grant != '0));

   p_full_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_full |-> rd_valid);

   p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && fifo_full) |=> ovf);

   p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   p_ovf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr && !(wr_req && fifo_full)) |=> !ovf);

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_hold
         p_hold_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[i] |=> $stable(chan_lvl[i]));
      end
   endgenerate

endmodule

bind beat_stamp_top beat_stamp_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cnt       (cnt_q),
   .chan_lvl  (chan_lvl),
   .ch_en     (ch_en),
   .grant     (grant),
   .wr_req    (wr_req),
   .fifo_full (fifo_full),
   .rd_valid  (rd_valid),
   .ovf       (ovf),
   .ovf_clr   (ovf_clr)
);

// File: tb/beat_stamp_top_bench.sv
module beat_stamp_top_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 4;
   localparam int CW    = 32;
   localparam int SYNC  = 2;
   localparam int FLEN  = 8;
   localparam int DEPTH = 16;
   localparam int CHW   = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] beat_in = '0;
   logic [NCH-1:0] ch_en = '0;
   logic           rd_en = 1'b0;
   logic           ovf_clr = 1'b0;
   logic           rd_valid;
   logic [CW-1:0]  rd_stamp;
   logic [CHW-1:0] rd_chan;
   logic           rd_rise;
   logic           fifo_full;
   logic           ovf;

   int  total = 0;
   int  bad = 0;
   bit  finished = 1'b0;

   logic [CW-1:0]  bcnt;
   logic [NCH-1:0] hist [SYNC+2];
   logic [NCH-1:0] mlvl;
   int             run [NCH];
   logic [CW:0]    expq [NCH][$];
   int             pop_ch [$];
   logic [CW-1:0]  pop_st [$];
   logic [NCH-1:0] cur_b = '0;
   logic [NCH-1:0] cur_e = '0;

   beat_stamp_top #(
      .NUM_CH (NCH), .CNT_W (CW), .SYNC_STAGES (SYNC),
      .FILT_LEN (FLEN), .FIFO_DEPTH (DEPTH)
   ) u_beat_stamp_top (
      .clk (clk), .rst_n (rst_n), .beat_in (beat_in), .ch_en (ch_en),
      .rd_en (rd_en), .ovf_clr (ovf_clr), .rd_valid (rd_valid),
      .rd_stamp (rd_stamp), .rd_chan (rd_chan), .rd_rise (rd_rise),
      .fifo_full (fifo_full), .ovf (ovf)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference cycle count as the requirements define it
   always_ff @(posedge clk) begin
      if (!rst_n) bcnt <= '0;
      else        bcnt <= bcnt + 32'd1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_left();
      int n = 0;
      for (int c = 0; c < NCH; c++) n += expq[c].size();
      return n;
   endfunction

   task automatic check_pop();
      int          c;
      logic [CW:0] e;
      c = int'(rd_chan);
      if (expq[c].size() == 0) begin
         chk(1'b0, "R6", "entry with no expected event on channel", c, -1);
      end else begin
         e = expq[c].pop_front();
         chk(rd_stamp == e[CW-1:0], "R2", "stamp", rd_stamp, e[CW-1:0]);
         chk(rd_rise == e[CW], "R4", "rise flag", rd_rise, e[CW]);
      end
      pop_ch.push_back(c);
      pop_st.push_back(rd_stamp);
   endtask

   // R3 / R10 rule applied to the sample the filter sees this cycle
   task automatic model_ch(input int c, input logic fv, input logic en);
      if (!en || fv == mlvl[c]) begin
         run[c] = 0;
      end else begin
         run[c]++;
         if (run[c] == FLEN) begin
            mlvl[c] = fv;
            run[c]  = 0;
            expq[c].push_back({fv, bcnt});
         end
      end
   endtask

   task automatic step(input logic [NCH-1:0] b, input logic [NCH-1:0] e,
                       input bit rd, input bit clr);
      @(negedge clk);
      if (rd && rd_valid) check_pop();
      rd_en   = rd;
      ovf_clr = clr;
      beat_in = b;
      ch_en   = e;
      for (int k = SYNC + 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = b;
      for (int c = 0; c < NCH; c++) model_ch(c, hist[SYNC+1][c], e[c]);
   endtask

   task automatic hold(input int n, input bit rd);
      for (int i = 0; i < n; i++) step(cur_b, cur_e, rd, 1'b0);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         report();
         $finish;
      end
   end

   initial begin
      int dur [NCH];
      int idx;
      void'($urandom(32'd4242));
      for (int k = 0; k < SYNC + 2; k++) hist[k] = '0;
      mlvl = '0;
      for (int c = 0; c < NCH; c++) run[c] = 0;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      step('0, '0, 1'b0, 1'b0);
      chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
      chk(fifo_full == 1'b0, "R1", "fifo_full after reset", fifo_full, 0);
      chk(ovf == 1'b0, "R1", "ovf after reset", ovf, 0);

      // single rising change on channel 1
      cur_e = '1;
      hold(5, 1'b1);
      pop_ch.delete();
      cur_b[1] = 1'b1;
      hold(30, 1'b1);
      chk(pop_ch.size() == 1, "R4", "entries for one change", pop_ch.size(), 1);
      if (pop_ch.size() > 0)
         chk(pop_ch[0] == 1, "R4", "channel index", pop_ch[0], 1);
      chk(exp_left() == 0, "R2", "expected entries left", exp_left(), 0);

      // glitch bursts on channel 0: one entry only
      pop_ch.delete();
      cur_b[0] = 1'b1; hold(3, 1'b1);
      cur_b[0] = 1'b0; hold(2, 1'b1);
      cur_b[0] = 1'b1; hold(7, 1'b1);
      cur_b[0] = 1'b0; hold(1, 1'b1);
      cur_b[0] = 1'b1; hold(30, 1'b1);
      cur_b[0] = 1'b0; hold(5, 1'b1);
      cur_b[0] = 1'b1; hold(25, 1'b1);
      chk(pop_ch.size() == 1, "R3", "entries from glitch burst", pop_ch.size(), 1);
      chk(exp_left() == 0, "R3", "expected entries left", exp_left(), 0);

      // all channels change in the same cycle
      cur_b = ~cur_b;
      hold(20, 1'b0);
      chk(rd_valid == 1'b1, "R7", "rd_valid with entries held", rd_valid, 1);
      pop_ch.delete();
      pop_st.delete();
      hold(10, 1'b1);
      chk(pop_ch.size() == NCH, "R5", "simultaneous entries", pop_ch.size(), NCH);
      if (pop_ch.size() == NCH) begin
         for (int i = 0; i < NCH; i++) begin
            chk(pop_ch[i] == i, "R5", "ascending channel order", pop_ch[i], i);
            chk(pop_st[i] == pop_st[0], "R5", "shared stamp", pop_st[i], pop_st[0]);
         end
      end
      chk(rd_valid == 1'b0, "R7", "rd_valid after drain", rd_valid, 0);

      // channel 2 disabled: no entries, level held
      pop_ch.delete();
      cur_e[2] = 1'b0;
      cur_b[2] = ~cur_b[2];
      hold(40, 1'b1);
      chk(pop_ch.size() == 0, "R10", "entries while disabled", pop_ch.size(), 0);
      chk(rd_valid == 1'b0, "R10", "rd_valid while disabled", rd_valid, 0);
      cur_e[2] = 1'b1;
      hold(30, 1'b1);
      chk(pop_ch.size() == 1, "R10", "entries after re-enable", pop_ch.size(), 1);
      if (pop_ch.size() > 0)
         chk(pop_ch[0] == 2, "R10", "re-enabled channel", pop_ch[0], 2);

      // overflow: 20 events into a 16-deep FIFO
      pop_ch.delete();
      for (int i = 0; i < 20; i++) begin
         cur_b[0] = ~cur_b[0];
         hold(12, 1'b0);
      end
      chk(fifo_full == 1'b1, "R8", "fifo_full", fifo_full, 1);
      chk(ovf == 1'b1, "R8", "ovf after discarded writes", ovf, 1);
      hold(25, 1'b1);
      chk(pop_ch.size() == DEPTH, "R8", "entries kept", pop_ch.size(), DEPTH);
      chk(expq[0].size() == 4, "R8", "events discarded", expq[0].size(), 4);
      expq[0].delete();
      chk(ovf == 1'b1, "R9", "ovf sticky after drain", ovf, 1);
      step(cur_b, cur_e, 1'b1, 1'b1);
      step(cur_b, cur_e, 1'b1, 1'b0);
      chk(ovf == 1'b0, "R9", "ovf after clear", ovf, 0);

      // constrained random run
      for (int c = 0; c < NCH; c++) dur[c] = 1 + c;
      for (int n = 0; n < 20000; n++) begin
         for (int c = 0; c < NCH; c++) begin
            dur[c]--;
            if (dur[c] <= 0) begin
               cur_b[c] = ~cur_b[c];
               if ($urandom % 4 == 0) dur[c] = 1 + int'($urandom % 3);
               else                   dur[c] = 6 + int'($urandom % 30);
            end
         end
         if ($urandom % 200 == 0) begin
            idx = int'($urandom % NCH);
            cur_e[idx] = ~cur_e[idx];
         end
         step(cur_b, cur_e, ($urandom % 10) != 0, 1'b0);
      end
      cur_e = '1;
      hold(60, 1'b1);
      chk(exp_left() == 0, "R6", "expected entries never seen", exp_left(), 0);
      chk(rd_valid == 1'b0, "R7", "rd_valid after final drain", rd_valid, 0);
      chk(ovf == 1'b0, "R8", "ovf after random run", ovf, 0);

      finished = 1'b1;
      report();
      $finish;
   end

endmodule